// File: doc/BRIEF.md
# Self-Filling Feedback Shift Register

This block is a four-stage shift register that needs no serial data from outside. A two-input logic gate feeds the first stage, and both inputs of that gate are outputs of the register's own stages. After reset is released and while enable is high, the register steps through a short repeating bit pattern on its own. The four stage outputs, A to D, appear together as a parallel bus.

Two plain control inputs choose the pattern. `tap_sel` picks which pair of stages drives the gate. `gate_sel` picks whether the gate is NOR or NAND. There is no data input, so there is no stream handshake. Every pin is a plain level, and `en` is the only thing that paces the register.

Top module: `sfsr_top`

## Requirements
- R1: While `rst_n` is low, `q` is 4'b0000 at once, without waiting for a clock edge. Bit mapping: A = `q[0]`, B = `q[1]`, C = `q[2]`, D = `q[3]`.
- R2: On each rising edge with `en` high, B takes the old A, C takes the old B and D takes the old C. The old D is lost.
- R3: With `tap_sel` = 2'b00 and `gate_sel` = 0, A takes NOR(A, B). Starting from reset, ABCD after edges 1 to 4 is 1000, 0100, 0010, 1001. After that, 0100, 0010, 1001 repeats with a period of 3.
- R4: Any nonzero `tap_sel` (2'b01, 2'b10 or 2'b11) feeds stages A and C to the gate instead of A and B.
- R5: `gate_sel` = 1 makes the gate a NAND. `gate_sel` = 0 makes it a NOR.
- R6: On a rising edge with `en` low, all four stages keep their values.
- R7: The gate samples `tap_sel` and `gate_sel` at each edge. A change made between two edges takes effect at the very next enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Shift enable; the register holds when this is low |
| tap_sel | input | 2 | 00 feeds A/B to the gate; any other value feeds A/C |
| gate_sel | input | 1 | 0 selects NOR, 1 selects NAND |
| q | output | 4 | Stage outputs, A in bit 0 through D in bit 3 |

## Verification
The reset result is due at once, because reset is asynchronous, and the bench checks `q` while reset is still held. Every shift result is due exactly one rising edge after the enabled cycle that produced it: there is one register between the gate and `q`. The bench drives its inputs on the falling edge, lets its behavioural model advance by one step, and compares the model with `q` just after the next rising edge. It does this for every tap and gate setting, and for cycles with enable low, where the expected value is the previous state.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
  localparam int unsigned STAGES = 4;
  typedef enum logic {
    GATE_NOR  = 1'b0,
    GATE_NAND = 1'b1
  } gate_e;
  typedef logic [STAGES-1:0] stage_vec_t;
endpackage

// File: rtl/sfsr_tap_pick.sv
module sfsr_tap_pick #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned SEL_W = 2,
  parameter int unsigned TAP_X = 0,
  parameter int unsigned TAP_Y0 = 1,
  parameter int unsigned TAP_Y1 = 2
) (
  input  logic [DEPTH-1:0] stages,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             tap_x,
  output logic             tap_y
);
  logic use_alt;
  assign use_alt = |tap_sel;
  assign tap_x   = stages[TAP_X];
  assign tap_y   = use_alt ? stages[TAP_Y1] : stages[TAP_Y0];
endmodule

// File: rtl/sfsr_fb_gate.sv
module sfsr_fb_gate
  import sfsr_pkg::*;
(
  input  logic  in_x,
  input  logic  in_y,
  input  gate_e kind,
  output logic  fb
);
  always_comb begin
    unique case (kind)
      GATE_NAND: fb = ~(in_x & in_y);
      default:   fb = ~(in_x | in_y);
    endcase
  end
endmodule

// File: rtl/sfsr_chain.sv
module sfsr_chain #(
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             serial_in,
  output logic [DEPTH-1:0] stages
);
  logic [DEPTH-1:0] next_in;
  assign next_in[0] = serial_in;
  for (genvar i = 1; i < DEPTH; i++) begin : g_link
    assign next_in[i] = stages[i-1];
  end
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  stages[i] <= 1'b0;
      else if (en) stages[i] <= next_in[i];
    end
  end
endmodule

// File: rtl/sfsr_top.sv
module sfsr_top
  import sfsr_pkg::*;
#(
  parameter int unsigned DEPTH = STAGES,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] tap_sel,
  input  logic             gate_sel,
  output logic [DEPTH-1:0] q
);
  logic  tap_x, tap_y, fb;
  gate_e kind;
  assign kind = gate_e'(gate_sel);

  sfsr_tap_pick #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_pick (
    .stages(q), .tap_sel(tap_sel), .tap_x(tap_x), .tap_y(tap_y)
  );
  sfsr_fb_gate u_gate (
    .in_x(tap_x), .in_y(tap_y), .kind(kind), .fb(fb)
  );
  sfsr_chain #(.DEPTH(DEPTH)) u_chain (
    .clk(clk), .rst_n(rst_n), .en(en), .serial_in(fb), .stages(q)
  );
endmodule

// File: rtl/sfsr_checker.sv
module sfsr_checker #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [SEL_W-1:0] tap_sel,
  input logic             gate_sel,
  input logic [DEPTH-1:0] q
);
  logic partner;
  assign partner = (tap_sel == '0) ? q[1] : q[2];

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> (q == '0));

  a_r2_shift_links: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (q[DEPTH-1:1] == $past(q[DEPTH-2:0])));

  // R3, R4, R5: stage A takes the selected gate of the selected pair
  a_r5_feedback: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (q[0] == $past(gate_sel ? ~(q[0] & partner) : ~(q[0] | partner))));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

bind sfsr_top sfsr_checker #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_sfsr_checker (
  .clk(clk), .rst_n(rst_n), .en(en), .tap_sel(tap_sel), .gate_sel(gate_sel), .q(q)
);

// File: tb/test_sfsr_top.sv
`timescale 1ns/1ps
module test_sfsr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] tap_sel = 2'b00;
  logic       gate_sel = 1'b0;
  logic [3:0] q;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  int a, b, c, d;   // reference model stages

  always #10 clk = ~clk;

  sfsr_top i_sfsr_top (
    .clk(clk), .rst_n(rst_n), .en(en), .tap_sel(tap_sel), .gate_sel(gate_sel), .q(q)
  );

  function automatic logic [3:0] model_q();
    return {d[0], c[0], b[0], a[0]};
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    compared++;
    if (q !== exp) begin
      mismatched++;
      $display("FAIL %s: q=%b expected %b at %0t", req, q, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0;
    #1;
    a = 0; b = 0; c = 0; d = 0;
    check("R1", 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one cycle: drive at falling edge, advance model, compare after rising edge
  task automatic step(input logic e, input logic [1:0] ts, input logic gs, input string req);
    int partner, fbv;
    @(negedge clk);
    en = e; tap_sel = ts; gate_sel = gs;
    if (e) begin
      partner = (ts == 2'b00) ? b : c;
      fbv = gs ? ((a == 1 && partner == 1) ? 0 : 1) : ((a == 0 && partner == 0) ? 1 : 0);
      d = c; c = b; b = a; a = fbv;
    end
    @(posedge clk);
    #2;
    check(req, model_q());
  endtask

  initial begin
    #(20ns * 200000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R3: literal sequence for NOR of A/B (A=q[0])
    do_reset();
    step(1, 2'b00, 0, "R3"); check("R3", 4'b0001);
    step(1, 2'b00, 0, "R3"); check("R3", 4'b0010);
    step(1, 2'b00, 0, "R3"); check("R3", 4'b0100);
    step(1, 2'b00, 0, "R3"); check("R3", 4'b1001);
    for (int k = 0; k < 3; k++) begin
      step(1, 2'b00, 0, "R3"); check("R3", 4'b0010);
      step(1, 2'b00, 0, "R3"); check("R3", 4'b0100);
      step(1, 2'b00, 0, "R3"); check("R3", 4'b1001);
    end

    // every tap code with both gates, R2/R4/R5 against the model
    for (int t = 0; t < 4; t++) begin
      for (int g = 0; g < 2; g++) begin
        do_reset();
        for (int k = 0; k < 14; k++)
          step(1, 2'(t), 1'(g), (t != 0) ? "R4" : (g != 0) ? "R5" : "R2");
      end
    end

    // R6: enable low holds the state
    do_reset();
    for (int k = 0; k < 3; k++) step(1, 2'b00, 1, "R2");
    for (int k = 0; k < 4; k++) step(0, 2'b01, 0, "R6");
    for (int k = 0; k < 3; k++) step(1, 2'b01, 1, "R6");

    // R7: selections changed every cycle take effect on the next edge
    do_reset();
    for (int k = 0; k < 16; k++)
      step(1, 2'(k % 3), 1'((k / 2) % 2), "R7");

    // R1: asynchronous reset in mid-pattern
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1 check("R1", 4'b0000);
    @(negedge clk);
    check("R1", 4'b0000);
    rst_n = 1'b1;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule